// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel flash device and waits until an embedded program or erase operation inside the device has finished. Once the host has issued the command sequence, it starts the poller with a mode, the polled address and the byte it expects. The poller then issues status reads, one at a time, over a simple synchronous read port. It decodes each returned byte and ends with a one-cycle done pulse, a pass flag and a 2-bit reason code.

Two modes are offered. Toggle mode watches status bit 6, which flips on every read while the device is busy. Data-polling mode compares status bit 7 against bit 7 of the expected byte. In both modes, status bit 5 is the device error flag. Because the status bit can settle in the same read that raises the error flag, the poller makes one extra read before it declares a device failure.

An optional verify read compares the whole byte with the expected value. A host-programmable poll limit stops a device that never completes.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, busy, done, pass and rd_req are 0 and reason is 2'b00.
- R2: A start seen while idle is taken at that clock edge. In the next cycle busy is 1 and rd_req is 1, with rd_addr equal to start_addr. rd_addr stays fixed until done. A start seen while busy is ignored.
- R3: At most one read is outstanding. rd_req is high for exactly one cycle and only while busy. The next request is raised in the cycle after the rd_valid that answers the previous one.
- R4: In toggle mode (start_mode=0), the first status read only records bit 6. Each later read whose bit 6 equals bit 6 of the previous read counts as completion, whatever bit 5 holds.
- R5: In toggle mode, a read whose bit 6 differs from the previous read while bit 5=1 causes exactly one recheck read. If bit 6 of the recheck equals bit 6 of the error read, the result is completion. Otherwise the result is a fail with reason 2'b01 (device error).
- R6: In data-polling mode (start_mode=1), a read whose bit 7 equals bit 7 of start_data counts as completion. A mismatch with bit 5=0 makes the poller continue polling.
- R7: In data-polling mode, a mismatch with bit 5=1 causes exactly one recheck read. If bit 7 of the recheck matches, the result is completion. Otherwise the result is a fail with reason 2'b01.
- R8: With start_verify=1, completion triggers one more read. If that byte equals start_data the result is a pass. Otherwise the result is a fail with reason 2'b10 (verify mismatch). With start_verify=0, completion is a pass with reason 2'b00.
- R9: Each ordinary poll read counts toward the limit; recheck and verify reads do not. A poll read that reaches count max_polls without completion and without an error ends in a fail with reason 2'b11 (poll limit). A max_polls of 0 acts as 1.
- R10: done is a one-cycle pulse and busy is 0 in that cycle. pass and reason hold their result until the next accepted start. pass=1 always comes with reason 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a polling run (taken when idle) |
| start_mode | input | 1 | 0 = toggle mode, 1 = data-polling mode |
| start_verify | input | 1 | 1 = read back and compare whole byte after completion |
| start_addr | input | ADDR_W | Address of the polled location |
| start_data | input | 8 | Expected byte |
| max_polls | input | CNT_W | Poll read limit (hold stable during a run) |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 8 | Returned byte |
| rd_valid | input | 1 | rd_data is valid this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run result, 1 = success |
| reason | output | 2 | 00 none, 01 device error, 10 verify mismatch, 11 poll limit |

## Verification
The bench builds the poller with ADDR_W=12 and CNT_W=4. Every value of the poll limit, from 0 up to the maximum of 15, can then be reached by a run of a few dozen cycles. Runs at limits 0, 1, 2, 3 and 15 place the limit check at the first read, at the toggle-mode first read, beside an error recheck, and at the very top of the counter. The read model answers two cycles after each request, so each run also exercises the wait between a request and its reply.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  localparam int BIT_DATA   = 7;
  localparam int BIT_TOGGLE = 6;
  localparam int BIT_ERROR  = 5;

  localparam logic MODE_TOGGLE = 1'b0;
  localparam logic MODE_DATA   = 1'b1;

  localparam logic [1:0] RSN_NONE   = 2'b00;
  localparam logic [1:0] RSN_DEVICE = 2'b01;
  localparam logic [1:0] RSN_VERIFY = 2'b10;
  localparam logic [1:0] RSN_LIMIT  = 2'b11;

  typedef enum logic [1:0] {
    PH_FIRST,
    PH_POLL,
    PH_RECHECK,
    PH_VERIFY
  } phase_t;

  typedef enum logic [2:0] {
    ACT_CONT,
    ACT_RECHECK,
    ACT_COMPLETE,
    ACT_FAIL_DEV,
    ACT_VERIFY_OK,
    ACT_VERIFY_BAD
  } act_t;

endpackage

// File: rtl/fsp_status_eval.sv
module fsp_status_eval
  import fsp_pkg::*;
(
  input  logic       mode,
  input  phase_t     phase,
  input  logic [7:0] rd_byte,
  input  logic       prev_tog,
  input  logic [7:0] exp_byte,
  output act_t       act
);

  logic settled;

  always_comb begin
    if (mode == MODE_TOGGLE) settled = (phase != PH_FIRST) && (rd_byte[BIT_TOGGLE] == prev_tog);
    else                     settled = (rd_byte[BIT_DATA] == exp_byte[BIT_DATA]);
  end

  always_comb begin
    if (phase == PH_VERIFY) begin
      act = (rd_byte == exp_byte) ? ACT_VERIFY_OK : ACT_VERIFY_BAD;
    end else if (settled) begin
      act = ACT_COMPLETE;
    end else if (phase == PH_RECHECK) begin
      act = ACT_FAIL_DEV;
    end else if (phase == PH_FIRST) begin
      act = ACT_CONT;
    end else if (rd_byte[BIT_ERROR]) begin
      act = ACT_RECHECK;
    end else begin
      act = ACT_CONT;
    end
  end

endmodule

// File: rtl/fsp_poll_limit.sv
module fsp_poll_limit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             count_en,
  input  logic [CNT_W-1:0] max_polls,
  output logic             limit_hit
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_next;

  assign cnt_next  = {1'b0, cnt_q} + EXT_W'(1);
  assign limit_hit = (cnt_next >= {1'b0, max_polls});

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (count_en && !limit_hit) begin
      cnt_q <= cnt_next[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fsp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_mode,
  input  logic              start_verify,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        start_data,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [1:0]        reason
);

  logic              busy_q, req_q, done_q, pass_q;
  logic [1:0]        rsn_q;
  logic [ADDR_W-1:0] addr_q;
  logic              mode_q, ver_q, prev_q;
  logic [7:0]        exp_q;
  phase_t            phase_q;

  logic   accept, got;
  act_t   act;
  logic   limit_hit;
  logic   reissue, finish, fin_pass;
  logic [1:0] fin_rsn;
  phase_t next_phase;

  assign accept = start && !busy_q;
  assign got    = busy_q && rd_valid && !req_q;

  fsp_status_eval u_eval (
    .mode     (mode_q),
    .phase    (phase_q),
    .rd_byte  (rd_data),
    .prev_tog (prev_q),
    .exp_byte (exp_q),
    .act      (act)
  );

  fsp_poll_limit #(.CNT_W(CNT_W)) u_limit (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .count_en  (got && (phase_q == PH_FIRST || phase_q == PH_POLL)),
    .max_polls (max_polls),
    .limit_hit (limit_hit)
  );

  always_comb begin
    reissue    = 1'b0;
    finish     = 1'b0;
    fin_pass   = 1'b0;
    fin_rsn    = RSN_NONE;
    next_phase = phase_q;
    unique case (act)
      ACT_CONT: begin
        if (limit_hit) begin
          finish  = 1'b1;
          fin_rsn = RSN_LIMIT;
        end else begin
          reissue    = 1'b1;
          next_phase = PH_POLL;
        end
      end
      ACT_RECHECK: begin
        reissue    = 1'b1;
        next_phase = PH_RECHECK;
      end
      ACT_COMPLETE: begin
        if (ver_q) begin
          reissue    = 1'b1;
          next_phase = PH_VERIFY;
        end else begin
          finish   = 1'b1;
          fin_pass = 1'b1;
        end
      end
      ACT_FAIL_DEV: begin
        finish  = 1'b1;
        fin_rsn = RSN_DEVICE;
      end
      ACT_VERIFY_OK: begin
        finish   = 1'b1;
        fin_pass = 1'b1;
      end
      default: begin
        finish  = 1'b1;
        fin_rsn = RSN_VERIFY;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      rsn_q   <= RSN_NONE;
      addr_q  <= '0;
      mode_q  <= MODE_TOGGLE;
      ver_q   <= 1'b0;
      prev_q  <= 1'b0;
      exp_q   <= '0;
      phase_q <= PH_FIRST;
    end else begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        req_q   <= 1'b1;
        pass_q  <= 1'b0;
        rsn_q   <= RSN_NONE;
        addr_q  <= start_addr;
        mode_q  <= start_mode;
        ver_q   <= start_verify;
        exp_q   <= start_data;
        phase_q <= (start_mode == MODE_DATA) ? PH_POLL : PH_FIRST;
      end else if (got) begin
        prev_q  <= rd_data[BIT_TOGGLE];
        phase_q <= next_phase;
        req_q   <= reissue;
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pass_q <= fin_pass;
          rsn_q  <= fin_rsn;
        end
      end
    end
  end

  assign rd_req  = req_q;
  assign rd_addr = addr_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign pass    = pass_q;
  assign reason  = rsn_q;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && rd_req)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(rd_addr)); // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R3
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (done && pass) |-> (reason == RSN_NONE)); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done && !(start && $past(!busy))) |-> ($stable(pass) && $stable(reason))); // R10

endmodule

// File: tb/flash_status_poller_bench.sv
`timescale 1ns/1ps
module flash_status_poller_bench;

  localparam int ADDR_W = 12;
  localparam int CNT_W  = 4;
  localparam int LAT    = 2;
  localparam int NV     = 17;
  localparam logic [7:0] EXP = 8'hA5;

  localparam bit          V_MODE  [NV] = '{0,0,0,0,0,0,1,1,1,1,1,1,1,0,0,1,0};
  localparam bit          V_VER   [NV] = '{0,1,1,0,0,0,0,0,0,1,1,0,0,0,0,0,0};
  localparam logic [3:0]  V_MAX   [NV] = '{8,8,8,8,8,3,8,8,8,8,8,2,0,1,8,2,15};
  localparam logic [127:0] V_RESP [NV] = '{
    128'h000040, 128'hA5000040, 128'hA4000040, 128'h602040, 128'h202040,
    128'h400040, 128'h800000, 128'h802000, 128'h2020, 128'hA580,
    128'h2580, 128'h0000, 128'h00, 128'h40, 128'h6040, 128'h802000,
    128'h40004000400040004000400040004000};
  localparam bit          V_PASS  [NV] = '{1,1,0,0,1,0,1,1,0,1,0,0,0,0,1,1,0};
  localparam logic [1:0]  V_RSN   [NV] = '{0,0,2,1,0,3,0,0,1,0,2,3,3,3,0,0,3};
  localparam int          V_READS [NV] = '{3,4,4,3,3,3,3,3,2,2,2,2,1,1,2,3,15};
  localparam string       V_REQ   [NV] = '{"R4","R8","R8","R5","R5","R9","R6","R7",
                                           "R7","R8","R8","R9","R9","R9","R4","R9","R9"};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0, start_mode = 1'b0, start_verify = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [7:0]        start_data = '0;
  logic [CNT_W-1:0]  max_polls = '0;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data = '0;
  logic              rd_valid = 1'b0;
  logic              busy, done, pass;
  logic [1:0]        reason;

  int total = 0;
  int bad = 0;

  logic [127:0]      cur_resp = '0;
  logic [ADDR_W-1:0] cur_addr = '0;
  logic              mem_clear = 1'b0;
  int                mem_idx = 0;
  int                mem_wait = 0;
  int                addr_bad = 0;
  int                req_dbl = 0;
  logic              prev_req = 1'b0;

  always #2 clk = ~clk;

  flash_status_poller #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_flash_status_poller (
    .clk(clk), .rst(rst), .start(start), .start_mode(start_mode),
    .start_verify(start_verify), .start_addr(start_addr), .start_data(start_data),
    .max_polls(max_polls), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .pass(pass), .reason(reason)
  );

  // device read model: answers LAT cycles after each request
  always @(negedge clk) begin
    rd_valid = 1'b0;
    if (mem_clear) begin
      mem_idx  = 0;
      mem_wait = 0;
    end
    if (mem_wait != 0) begin
      mem_wait = mem_wait - 1;
      if (mem_wait == 0) begin
        rd_valid = 1'b1;
        rd_data  = cur_resp[(mem_idx % 16) * 8 +: 8];
        mem_idx  = mem_idx + 1;
      end
    end
    if (rd_req) begin
      mem_wait = LAT;
      if (rd_addr != cur_addr) addr_bad = addr_bad + 1;
    end
    if (rd_req && prev_req) req_dbl = req_dbl + 1;
    prev_req = rd_req;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input bit mode, input bit ver, input logic [3:0] maxp,
                     input logic [127:0] resp, input logic [ADDR_W-1:0] addr,
                     input bit exp_pass, input logic [1:0] exp_rsn, input int exp_reads,
                     input string tag, input bit inject);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    cur_resp = resp; cur_addr = addr; mem_clear = 1'b1;
    start = 1'b1; start_mode = mode; start_verify = ver;
    start_addr = addr; start_data = EXP; max_polls = maxp;
    @(negedge clk);
    start = 1'b0; mem_clear = 1'b0;
    chk(busy && rd_req && rd_addr == addr, "R2", "busy/req/addr after start",
        {busy, rd_req, rd_addr == addr}, 3'b111);
    for (int k = 0; k < 400; k++) begin
      if (inject && k == 3) begin
        start = 1'b1; start_mode = ~mode; start_addr = ~addr; start_data = 8'h00;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    start = 1'b0;
    chk(seen, tag, "done seen", seen, 1);
    if (seen) begin
      chk(!busy, "R10", "busy low with done", busy, 0);
      chk(pass == exp_pass, tag, "pass", pass, exp_pass);
      chk(reason == exp_rsn, tag, "reason", reason, exp_rsn);
      chk(mem_idx == exp_reads, tag, "read count", mem_idx, exp_reads);
      @(negedge clk);
      @(negedge clk);
      chk(!done && pass == exp_pass && reason == exp_rsn, "R10", "result held after done",
          {done, pass, reason}, {1'b0, exp_pass, exp_rsn});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !pass && !rd_req && reason == 2'b00, "R1", "reset state",
        {busy, done, pass, rd_req, reason}, 0);

    for (int i = 0; i < NV; i++) begin
      run(V_MODE[i], V_VER[i], V_MAX[i], V_RESP[i], ADDR_W'(12'h100 + i),
          V_PASS[i], V_RSN[i], V_READS[i], V_REQ[i], 1'b0);
    end

    // R2: a start raised mid-run is ignored (address and mode unchanged)
    run(1'b0, 1'b0, 4'd8, 128'h000040, 12'h155, 1'b1, 2'b00, 3, "R2", 1'b1);
    chk(addr_bad == 0, "R2", "read address mismatches", addr_bad, 0);
    chk(req_dbl == 0, "R3", "back-to-back requests", req_dbl, 0);

    // R3: no request while a read is outstanding
    @(negedge clk);
    cur_resp = 128'h800000; cur_addr = 12'h321; mem_clear = 1'b1;
    start = 1'b1; start_mode = 1'b1; start_verify = 1'b0;
    start_addr = 12'h321; start_data = EXP; max_polls = 4'd8;
    @(negedge clk);
    start = 1'b0; mem_clear = 1'b0;
    @(negedge clk);
    chk(!rd_req, "R3", "no request while waiting", rd_req, 0);
    @(negedge clk);
    chk(!rd_req, "R3", "no request before reply", rd_req, 0);
    @(negedge clk);
    chk(rd_req, "R3", "request after reply", rd_req, 1);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(pass && mem_idx == 3, "R6", "data poll after wait check", mem_idx, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule